// File: doc/BRIEF.md
# Two-Way Inter-Core Mailbox

This block lets two processor cores pass 32-bit messages to each other. It holds two one-way queues. One carries words from core 0 to core 1 and the other carries words from core 1 to core 0. Both cores share a single access port. A one-bit core-identity input says which core owns the access in the current cycle. That input steers a send to the queue this core feeds, and a receive to the queue the other core feeds.

Each core sees its own four-bit status word, sampled through the same port. The status word gives two live conditions: a word is waiting to be read, and there is room to send. It also gives two sticky error flags. One records a send attempted into a full queue. The other records a receive attempted from an empty queue. Either misuse leaves the stored data untouched. Any write to the status word clears the writing core's two flags. Each core also gets an interrupt-request output. It is high while that core has a word to read or has either error flag raised.

The read data and the status word are combinational views of the current state for the core named on `core_id`. Sends, receives and status writes take effect at the rising clock edge.

Top module: `mbx_pair`

## Requirements
- R1: After reset both queues are empty. Every core's status reads valid=0, ready=1 and both flags 0 (status 4'b0010). `rx_data` is 0 and `irq` is 2'b00.
- R2: Words sent by one core are received by the other core in the order they were sent. `rx_data` shows the oldest waiting word, and a receive strobe removes it at the clock edge.
- R3: A word sent by core N never appears in core N's own receive view. It is visible only to the other core.
- R4: Status bit 0 (valid) is 1 exactly when the accessing core's receive queue holds at least one word.
- R5: Status bit 1 (ready) is 1 exactly when the accessing core's send queue holds fewer than DEPTH (default 4) words.
- R6: A send into a full queue discards the word and leaves the queue unchanged. It sets status bit 2 (write-overflow flag) of the sending core.
- R7: A receive from an empty queue returns 0 on `rx_data` and moves no pointer. It sets status bit 3 (read-underflow flag) of the receiving core.
- R8: A status write (`st_wr`) clears bits 2 and 3 of the core named on `core_id` and no other core's flags. Flags otherwise stay set until cleared.
- R9: When a status write and a new misuse by the same core fall in the same cycle, the flag ends up set.
- R10: `irq[N]` is 1 whenever core N's valid bit or either of its sticky flags is 1, and 0 otherwise.
- R11: A send and a receive strobed together by one core both take effect in the same cycle, each on its own queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_id | input | 1 | Identity of the core driving this cycle's access (0 or 1) |
| tx_wr | input | 1 | Send strobe: push `tx_data` into this core's outgoing queue |
| tx_data | input | DATA_W | Word to send |
| rx_rd | input | 1 | Receive strobe: remove the word shown on `rx_data` |
| st_wr | input | 1 | Status write: clear this core's sticky flags |
| rx_data | output | DATA_W | Oldest word in this core's incoming queue, 0 when empty |
| status | output | 4 | {underflow flag, overflow flag, ready, valid} for this core |
| irq | output | 2 | Per-core interrupt request, bit N for core N |

## Verification
Two situations can land in one cycle, and the bench provokes both.

The first is a status write that clears the flags while the same core sends into its full queue. The bench fills core 0's queue to DEPTH, then strobes `tx_wr` and `st_wr` together. It judges the outcome by core 0's status one cycle later, which must still show the overflow flag. It also checks that the receiving core gets back only the original words.

The second is a send and a receive by one core in the same cycle. One table row strobes both for core 1. The next rows confirm two things: the removed word is gone from core 1's incoming queue, and the new word reaches core 0.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // Bit positions inside the per-core status word; software decodes these.
   localparam int ST_VALID = 0;
   localparam int ST_READY = 1;
   localparam int ST_WOVF  = 2;
   localparam int ST_RUDF  = 3;
   localparam int ST_W     = 4;
   localparam int N_CORES  = 2;

   typedef struct packed {
      logic rudf;
      logic wovf;
      logic ready;
      logic valid;
   } mbx_stat_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              push,
   input  logic                              pop,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [DATA_W-1:0]                 head,
   output logic [$clog2(DEPTH+1)-1:0]        level,
   output logic                              empty,
   output logic                              full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mbx_fifo: DEPTH must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("mbx_fifo: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic [CNT_W-1:0]  cnt;
   logic              do_push;
   logic              do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = store[rd_ptr];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (do_push) begin
         store[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (do_pop) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/mbx_err_flags.sv
module mbx_err_flags #(
   parameter int SET_WINS = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       core_id,
   input  logic       ovf_ev,
   input  logic       udf_ev,
   input  logic       clr,
   output logic [1:0] wovf,
   output logic [1:0] rudf
);
   for (genvar c = 0; c < mbx_pkg::N_CORES; c++) begin : g_core
      logic mine;
      logic set_w;
      logic set_r;
      logic clr_c;
      logic nxt_w;
      logic nxt_r;

      assign mine  = (core_id == 1'(c));
      assign set_w = ovf_ev & mine;
      assign set_r = udf_ev & mine;
      assign clr_c = clr & mine;

      if (SET_WINS != 0) begin : g_set_first
         assign nxt_w = set_w | (wovf[c] & ~clr_c);
         assign nxt_r = set_r | (rudf[c] & ~clr_c);
      end else begin : g_clr_first
         assign nxt_w = (set_w | wovf[c]) & ~clr_c;
         assign nxt_r = (set_r | rudf[c]) & ~clr_c;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wovf[c] <= 1'b0;
            rudf[c] <= 1'b0;
         end else begin
            wovf[c] <= nxt_w;
            rudf[c] <= nxt_r;
         end
      end
   end
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair #(
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 4,
   parameter int SET_WINS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_id,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_rd,
   input  logic              st_wr,
   output logic [DATA_W-1:0] rx_data,
   output logic [3:0]        status,
   output logic [1:0]        irq
);
   import mbx_pkg::*;

   localparam int CNT_W = $clog2(DEPTH + 1);

   // Queue g carries words from core g to core 1-g.
   logic [DATA_W-1:0] head  [N_CORES];
   logic [CNT_W-1:0]  lvl   [N_CORES];
   logic [1:0]        q_empty;
   logic [1:0]        q_full;
   logic [1:0]        wovf;
   logic [1:0]        rudf;
   logic              tx_i;
   logic              rx_i;
   mbx_stat_t         st;

   assign tx_i = core_id;
   assign rx_i = ~core_id;

   for (genvar g = 0; g < N_CORES; g++) begin : g_q
      logic q_push;
      logic q_pop;
      assign q_push = tx_wr & (core_id == 1'(g));
      assign q_pop  = rx_rd & (core_id == 1'(1 - g));

      mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (q_push),
         .pop   (q_pop),
         .wdata (tx_data),
         .head  (head[g]),
         .level (lvl[g]),
         .empty (q_empty[g]),
         .full  (q_full[g])
      );

      assign irq[g] = ~q_empty[1 - g] | wovf[g] | rudf[g];
   end

   mbx_err_flags #(.SET_WINS(SET_WINS)) u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .core_id (core_id),
      .ovf_ev  (tx_wr & q_full[tx_i]),
      .udf_ev  (rx_rd & q_empty[rx_i]),
      .clr     (st_wr),
      .wovf    (wovf),
      .rudf    (rudf)
   );

   assign st.valid = ~q_empty[rx_i];
   assign st.ready = ~q_full[tx_i];
   assign st.wovf  = wovf[core_id];
   assign st.rudf  = rudf[core_id];
   assign status   = st;
   assign rx_data  = q_empty[rx_i] ? '0 : head[rx_i];
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
   parameter int DEPTH    = 4,
   parameter int CNT_W    = 3,
   parameter int SET_WINS = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             core_id,
   input logic             tx_wr,
   input logic             rx_rd,
   input logic             st_wr,
   input logic [3:0]       status,
   input logic [1:0]       irq,
   input logic [CNT_W-1:0] lvl0,
   input logic [CNT_W-1:0] lvl1,
   input logic [1:0]       wovf,
   input logic [1:0]       rudf
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl0 <= CNT_W'(DEPTH)) && (lvl1 <= CNT_W'(DEPTH)));  // R5

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && core_id == 1'b0 && lvl0 == CNT_W'(DEPTH))
      |=> (lvl0 == CNT_W'(DEPTH) && wovf[0]));  // R6

   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && core_id == 1'b1 && lvl0 == '0)
      |=> (lvl0 == '0 && rudf[1]));  // R7

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wovf[1] && !(st_wr && core_id == 1'b1)) |=> wovf[1]);  // R8

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((SET_WINS != 0) && st_wr && rx_rd && core_id == 1'b0 && lvl1 == '0)
      |=> rudf[0]);  // R9

   AST_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] == (core_id ? (lvl0 != '0) : (lvl1 != '0)));  // R4

   AST_IRQ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl1 != '0) |-> irq[0]);  // R10
endmodule

bind mbx_pair mbx_pair_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .SET_WINS(SET_WINS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .core_id (core_id),
   .tx_wr   (tx_wr),
   .rx_rd   (rx_rd),
   .st_wr   (st_wr),
   .status  (status),
   .irq     (irq),
   .lvl0    (lvl[0]),
   .lvl1    (lvl[1]),
   .wovf    (wovf),
   .rudf    (rudf)
);

// File: tb/sim_mbx_pair.sv
module sim_mbx_pair;
   localparam int DATA_W = 32;
   localparam int DEPTH  = 4;
   localparam int N_VEC  = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              core_id = 1'b0;
   logic              tx_wr = 1'b0;
   logic [DATA_W-1:0] tx_data = '0;
   logic              rx_rd = 1'b0;
   logic              st_wr = 1'b0;
   logic [DATA_W-1:0] rx_data;
   logic [3:0]        status;
   logic [1:0]        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mbx_pair #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .core_id(core_id), .tx_wr(tx_wr),
      .tx_data(tx_data), .rx_rd(rx_rd), .st_wr(st_wr),
      .rx_data(rx_data), .status(status), .irq(irq)
   );

   // Row: {req[3:0], core, send, recv, stwr, data[31:0], exp_status[3:0], exp_rx[31:0], exp_irq[1:0]}
   // Expected values are the view before the row's clock edge.
   localparam logic [77:0] VEC [N_VEC] = '{
      {4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 32'hA000_0001, 4'b0010, 32'h0,          2'b00}, // R2 first send
      {4'd10, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA000_0002, 4'b0010, 32'h0,          2'b10}, // R10 irq1 rises
      {4'd2,  1'b1, 1'b0, 1'b1, 1'b0, 32'h0,         4'b0011, 32'hA000_0001, 2'b10}, // R2 order
      {4'd11, 1'b1, 1'b1, 1'b1, 1'b0, 32'hB000_0003, 4'b0011, 32'hA000_0002, 2'b10}, // R11 send+recv
      {4'd3,  1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         4'b0011, 32'hB000_0003, 2'b01}, // R3 core0 sees core1 word
      {4'd7,  1'b1, 1'b0, 1'b1, 1'b0, 32'h0,         4'b0010, 32'h0,          2'b00}, // R7 read empty
      {4'd7,  1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         4'b1010, 32'h0,          2'b10}, // R7 flag set
      {4'd8,  1'b0, 1'b0, 1'b0, 1'b1, 32'h0,         4'b0010, 32'h0,          2'b10}, // R8 core0 clear
      {4'd8,  1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         4'b1010, 32'h0,          2'b10}, // R8 core1 untouched
      {4'd8,  1'b1, 1'b0, 1'b0, 1'b1, 32'h0,         4'b1010, 32'h0,          2'b10}, // R8 core1 clear
      {4'd8,  1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         4'b0010, 32'h0,          2'b00}  // R8 cleared
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Applies inputs at the next falling edge and settles before checks.
   task automatic apply(input logic c, input logic w, input logic r, input logic s,
                        input logic [31:0] d);
      @(negedge clk);
      core_id = c; tx_wr = w; rx_rd = r; st_wr = s; tx_data = d;
      #1;
   endtask

   task automatic look(input logic c);
      apply(c, 1'b0, 1'b0, 1'b0, 32'h0);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state, both cores
      look(1'b0);
      chk("R1 status core0", 32'(status), 32'h2);
      chk("R1 rx_data", rx_data, 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
      look(1'b1);
      chk("R1 status core1", 32'(status), 32'h2);

      for (int i = 0; i < N_VEC; i++) begin
         logic [77:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d row %0d", v[77:74], i);
         apply(v[73], v[72], v[71], v[70], v[69:38]);
         chk({tag, " status"}, 32'(status), 32'(v[37:34]));
         chk({tag, " rx_data"}, rx_data, v[33:2]);
         chk({tag, " irq"}, 32'(irq), 32'(v[1:0]));
      end

      // R5: fill core0's queue
      for (int k = 0; k < DEPTH; k++) begin
         apply(1'b0, 1'b1, 1'b0, 1'b0, 32'h10 + 32'(k));
         chk("R5 ready before full", 32'(status[1]), 32'h1);
      end
      look(1'b0);
      chk("R5 core0 not ready when full", 32'(status), 32'h0);
      look(1'b1);
      chk("R4 core1 valid with data", 32'(status), 32'h3);

      // R6: overflow drops word and flags core0
      apply(1'b0, 1'b1, 1'b0, 1'b0, 32'h99);
      look(1'b0);
      chk("R6 overflow flag", 32'(status), 32'h4);
      chk("R10 irq both", 32'(irq), 32'h3);

      // R9: clear and new overflow in one cycle
      apply(1'b0, 1'b1, 1'b0, 1'b1, 32'h98);
      look(1'b0);
      chk("R9 set beats clear", 32'(status), 32'h4);

      // R6/R2: core1 drains only the original words, in order
      for (int k = 0; k < DEPTH; k++) begin
         apply(1'b1, 1'b0, 1'b1, 1'b0, 32'h0);
         chk("R6 contents kept", rx_data, 32'h10 + 32'(k));
      end
      look(1'b1);
      chk("R6 queue empty after drain", 32'(status), 32'h2);
      chk("R7 empty reads zero", rx_data, 32'h0);

      // R8: status write clears core0
      apply(1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
      look(1'b0);
      chk("R8 core0 cleared", 32'(status), 32'h2);
      chk("R10 irq idle", 32'(irq), 32'h0);

      // R1: reset in mid-operation
      apply(1'b1, 1'b1, 1'b0, 1'b0, 32'h55);
      apply(1'b1, 1'b0, 1'b1, 1'b0, 32'h0);
      @(negedge clk);
      rst_n = 1'b0;
      tx_wr = 1'b0; rx_rd = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      look(1'b0);
      chk("R1 status after reset", 32'(status), 32'h2);
      chk("R1 rx after reset", rx_data, 32'h0);
      chk("R1 irq after reset", 32'(irq), 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule